// File: doc/BRIEF.md
# Clock-Gated Moore State Machine

This block is a four-state Moore machine whose state register is clocked only when the state is about to change. A clock-activation stage looks at the present state and the single primary input and works out whether the coming edge would leave the state as it is, which is a self-loop in the transition graph. When it would, the register's clock is held low for that cycle, so the state flip-flops see no edge while the machine holds.

The enable is captured by a level-sensitive latch that is open while the clock is low. The latched value is ANDed with the clock, so the enable cannot change during the high phase and the gated clock cannot glitch. A parameter selects a second variant for flows that avoid derived clocks. In that variant the same latched enable acts as a register enable on the free-running clock. The state sequence is identical in both variants. The Moore output is decoded from the state alone. The gated clock and its enable are brought out so that the gating can be observed.

Top module: `cg_moore_fsm`

## Requirements
- R1: The output `y_o` depends on the present state only: IDLE (code 00) gives 00, ARM (01) gives 01, WAIT (10) gives 11, DONE (11) gives 10. A change on `x_i` between clock edges leaves `y_o` unchanged.
- R2: Transitions on each rising clock edge: IDLE stays on x=0 and goes to ARM on x=1; ARM goes to WAIT on x=0 and to DONE on x=1; WAIT stays on x=1 and goes to DONE on x=0; DONE stays on x=0 and goes to IDLE on x=1.
- R3: While the clock is low, `clk_en_o` is 0 exactly for the three self-loop pairs (IDLE with x=0, WAIT with x=1, DONE with x=0) and 1 for every other pair.
- R4: `gclk_o` has no rising edge in a cycle whose state and input select a self-loop, and exactly one rising edge in every other cycle.
- R5: `clk_en_o` holds the value it had at the rising edge for the whole high phase of the clock, even when the state changes during that phase.
- R6: Driving `rst_n` low forces the state to IDLE (`y_o` = 00) at once, without any clock edge, even while the gating enable is 0.
- R7: For any input stream, the sequence of `y_o` values matches the sequence of an ungated reference machine, cycle by cycle.
- R8: With `GATE_MODE` = 1, the register runs on the free-running clock and uses the latched enable as a load enable. Its `y_o` sequence is the same as with `GATE_MODE` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Primary input of the machine |
| y_o | output | 2 | Moore output decoded from the state |
| clk_en_o | output | 1 | Latched clock-activation enable |
| gclk_o | output | 1 | Clock ANDed with the latched enable |

## Verification
The bench visits all eight state and input pairs, then runs a long random stream. On every cycle it counts rising edges of `gclk_o`. A design that gates on the wrong pairs either loses a needed edge, so the state freezes and `y_o` departs from the model, or gives a spurious edge that the edge count reports. The bench also toggles `x_i` during the low phase and checks the latched enable once the clock has risen. A design without the latch would let the enable follow the new state in the high phase, which would show up as a changed `clk_en_o` or a glitch on `gclk_o`. Reset is applied while the machine sits in a gated self-loop, to catch a reset path that waits for a clock that never arrives. Finally, a second instance in register-enable mode must follow the same `y_o` sequence on every cycle.

// File: rtl/cgfsm_pkg.sv
package cgfsm_pkg;

   localparam int ST_W  = 2;
   localparam int OUT_W = 2;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE = 2'b00,
      ST_ARM  = 2'b01,
      ST_WAIT = 2'b10,
      ST_DONE = 2'b11
   } st_t;

   // Fixed transition graph; three pairs are self-loops
   function automatic st_t next_state(st_t s, logic x);
      st_t n;
      unique case (s)
         ST_IDLE: n = x ? ST_ARM  : ST_IDLE;
         ST_ARM:  n = x ? ST_DONE : ST_WAIT;
         ST_WAIT: n = x ? ST_WAIT : ST_DONE;
         default: n = x ? ST_IDLE : ST_DONE;
      endcase
      return n;
   endfunction

   // Moore decode: depends on the state alone
   function automatic logic [OUT_W-1:0] moore_out(st_t s);
      logic [OUT_W-1:0] y;
      unique case (s)
         ST_IDLE: y = 2'b00;
         ST_ARM:  y = 2'b01;
         ST_WAIT: y = 2'b11;
         default: y = 2'b10;
      endcase
      return y;
   endfunction

endpackage

// File: rtl/cgfsm_activation.sv
module cgfsm_activation
   import cgfsm_pkg::*;
(
   input  st_t  st_i,
   input  logic x_i,
   output st_t  nxt_o,
   output logic en_o
);
   st_t nxt;

   always_comb begin
      nxt = next_state(st_i, x_i);
   end

   assign nxt_o = nxt;
   // Clock is needed only when the state would move
   assign en_o  = (nxt != st_i);

endmodule

// File: rtl/cgfsm_gate_cell.sv
module cgfsm_gate_cell (
   input  logic clk,
   input  logic en_i,
   output logic en_lat_o,
   output logic gclk_o
);
   logic en_lat;

   // Open while clk is low, closed through the high phase
   always_latch begin
      if (!clk) en_lat = en_i;
   end

   assign en_lat_o = en_lat;
   assign gclk_o   = clk & en_lat;

endmodule

// File: rtl/cgfsm_state_reg.sv
module cgfsm_state_reg
   import cgfsm_pkg::*;
#(
   parameter st_t RESET_STATE = ST_IDLE
) (
   input  logic clk,
   input  logic reg_clk,
   input  logic rst_n,
   input  logic en_i,
   input  st_t  d_i,
   output st_t  q_o
);
   st_t q;

   always_ff @(posedge reg_clk or negedge rst_n) begin
      if (!rst_n)    q <= RESET_STATE;
      else if (en_i) q <= d_i;
   end

   assign q_o = q;

   AST_HOLD_ON_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> q == $past(q)); // R4

   AST_LOAD_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> q == $past(d_i)); // R2

   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |-> q == RESET_STATE); // R6

endmodule

// File: rtl/cg_moore_fsm.sv
module cg_moore_fsm
   import cgfsm_pkg::*;
#(
   parameter int  GATE_MODE   = 0,
   parameter st_t RESET_STATE = ST_IDLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             x_i,
   output logic [OUT_W-1:0] y_o,
   output logic             clk_en_o,
   output logic             gclk_o
);
   st_t  st, nxt;
   logic en_raw, en_lat, gclk, reg_clk;

   if (GATE_MODE != 0 && GATE_MODE != 1) begin : g_bad_mode
      $error("GATE_MODE must be 0 or 1");
   end

   cgfsm_activation u_act (
      .st_i (st),
      .x_i  (x_i),
      .nxt_o(nxt),
      .en_o (en_raw)
   );

   cgfsm_gate_cell u_gate (
      .clk     (clk),
      .en_i    (en_raw),
      .en_lat_o(en_lat),
      .gclk_o  (gclk)
   );

   if (GATE_MODE == 0) begin : g_clock_gate
      assign reg_clk = gclk;
   end else begin : g_load_enable
      assign reg_clk = clk;
   end

   cgfsm_state_reg #(.RESET_STATE(RESET_STATE)) u_reg (
      .clk    (clk),
      .reg_clk(reg_clk),
      .rst_n  (rst_n),
      .en_i   (en_lat),
      .d_i    (nxt),
      .q_o    (st)
   );

   assign y_o      = moore_out(st);
   assign clk_en_o = en_lat;
   assign gclk_o   = gclk;

   AST_GATE_ONLY_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_lat |-> ((st == ST_IDLE && !x_i) || (st == ST_WAIT && x_i) ||
                   (st == ST_DONE && !x_i))); // R3

endmodule

// File: tb/sim_cg_moore_fsm.sv
`timescale 1ns/1ps
module sim_cg_moore_fsm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       x = 1'b0;
   logic [1:0] y0, y1;
   logic       en0, en1, gclk0, gclk1;

   int checks = 0;
   int failures = 0;
   int edges = 0;
   int ref_s = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cg_moore_fsm #(.GATE_MODE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .x_i(x),
      .y_o(y0), .clk_en_o(en0), .gclk_o(gclk0)
   );

   cg_moore_fsm #(.GATE_MODE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .x_i(x),
      .y_o(y1), .clk_en_o(en1), .gclk_o(gclk1)
   );

   always @(posedge gclk0) edges++;

   function automatic int ref_next(int s, bit xv);
      case (s)
         0: return xv ? 1 : 0;
         1: return xv ? 3 : 2;
         2: return xv ? 2 : 3;
         default: return xv ? 0 : 3;
      endcase
   endfunction

   function automatic logic [1:0] ref_out(int s);
      logic [1:0] b;
      b = 2'(s);
      return b ^ (b >> 1);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Called just after a falling edge; returns just after the next one
   task automatic step(bit xv, bit wiggle);
      int  e0;
      bit  moves;
      logic [1:0] y_before;
      y_before = y0;
      if (wiggle) begin
         x = ~xv;
         #0.5;
         check(y0 == y_before, "R1", y0, y_before);
      end
      x = xv;
      moves = (ref_next(ref_s, xv) != ref_s);
      #1;
      check(en0 == moves, "R3", en0, moves);
      check(y0 == y_before, "R1", y0, y_before);
      e0 = edges;
      @(posedge clk);
      #1;
      check(en0 == moves, "R5", en0, moves);
      ref_s = ref_next(ref_s, xv);
      @(negedge clk);
      #0.2;
      check(y0 == ref_out(ref_s), "R2 R7", y0, ref_out(ref_s));
      check((edges - e0) == (moves ? 1 : 0), "R4", edges - e0, moves ? 1 : 0);
      check(y1 == y0, "R8", y1, y0);
   endtask

   initial begin
      #1 rst_n = 1'b0;
      #0.5;
      check(y0 == 2'b00, "R6", y0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.2;
      check(y0 == 2'b00 && y1 == 2'b00, "R6", y0, 0);
      ref_s = 0;
      // directed walk through all eight state/input pairs
      step(0, 0); step(1, 0); step(1, 0); step(1, 0);
      step(1, 1); step(0, 0); step(1, 0); step(1, 1);
      step(0, 1); step(0, 0); step(0, 0); step(1, 0);
      // reset while parked in a gated self-loop (DONE, x=0)
      step(1, 0); step(0, 0); step(0, 0);
      check(en0 == 1'b0, "R3", en0, 0);
      #0.5 rst_n = 1'b0;
      #0.5;
      check(y0 == 2'b00, "R6", y0, 0);
      check(y1 == 2'b00, "R6", y1, 0);
      @(negedge clk);
      rst_n = 1'b1;
      ref_s = 0;
      #0.2;
      // random stream against the reference
      for (int i = 0; i < 400; i++) begin
         step(1'($urandom_range(0, 1)), (i % 7) == 3);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule